// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block holds one general register of a timer channel together with the pin logic around it. A 4-bit control code picks the role of both. As an output-compare register, the block drives the channel pin. Writing an active output code sets the pin to a starting level straight away. After that, each cycle in which the external free-running counter equals the register applies the selected action: drive low, drive high or toggle. As an input-capture register, the block copies the counter value into the register when a chosen edge appears on the synchronized pin. In a channel built for cascading, the trigger can instead be an event pulse from a companion channel.

Software loads the register through a write port and changes the control code through a strobed write. It reads the register value and two sticky flags, one for compare match and one for capture. It clears each flag with a strobe. The parameter `CASCADE` selects whether the channel can take its trigger from the companion channel.

Top module: `tcc_pin_ctrl`

## Requirements
- R1: After synchronous reset the control code is 0000, `pin_oe` and `pin_out` are 0, both flags are 0 and `reg_out` is 0.
- R2: Writing a control code with bit 3 = 0 and bits 1:0 != 00 sets `pin_out` to code bit 2 and `pin_oe` to 1 in the cycle after the write, before any compare match.
- R3: In an output code, a cycle where `cnt` equals the register applies the action selected by bits 1:0 at the next clock edge: 01 drives 0, 10 drives 1, 11 inverts the pin.
- R4: Codes 0000 and 0100 hold `pin_oe` low, and `pin_out` keeps its last value, including across compare matches.
- R5: While bit 3 = 0, every cycle with `cnt` equal to the register sets `match_flag`. The flag stays set until a `flag_clr[0]` strobe; a new match in the same cycle as a clear wins.
- R6: With bit 3 = 1, the pin passes through a two-flop synchronizer. Bits 1:0 select the capture edge: 00 rising, 01 falling, 1x both. The register takes `cnt` on the third rising clock edge after the pin changes. No capture happens while bit 3 = 0.
- R7: With `CASCADE` = 1, code 11xx captures `cnt` in the cycle `companion_evt` is high and ignores pin edges; codes 10xx ignore `companion_evt`.
- R8: With `CASCADE` = 0, bit 2 is ignored when bit 3 = 1: 11xx behaves as 10xx and `companion_evt` never captures.
- R9: Each capture sets `cap_flag`. The flag stays set until a `flag_clr[1]` strobe; a capture in the same cycle as a clear wins.
- R10: With bit 3 = 1, `pin_oe` is 0 and `match_flag` is never set. `wr_en` loads `wr_data` into the register in any mode, and a capture in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Free-running counter value |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CNT_W | Register write data |
| ctl_wr | input | 1 | Control code write strobe |
| ctl_code | input | 4 | New control code |
| flag_clr | input | 2 | Clear strobes: bit 0 match flag, bit 1 capture flag |
| pin_in | input | 1 | Asynchronous channel pin input |
| companion_evt | input | 1 | Match/capture pulse from the companion channel |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| reg_out | output | CNT_W | Current register value |
| match_flag | output | 1 | Sticky compare-match flag |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The embedded assertions check several rules on every cycle. A control write of an active output code must leave the starting level on the pin. Each match action must produce its level. A disabled pin must stay frozen. Each match or capture must set its flag, and a capture must store the counter value. The output enable must stay low in capture mode. Other behaviour only shows through the bench's sweeps. These cover the code-to-behaviour mapping across all sixteen codes, the three-cycle synchronizer delay, edge selection against rising, falling and companion stimuli, and the difference between cascade-capable and plain channels.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RISE,
        SRC_FALL,
        SRC_BOTH,
        SRC_CHAIN
    } cap_src_e;

    typedef struct packed {
        logic     is_cap;
        logic     init_lvl;
        act_e     act;
        cap_src_e src;
    } cfg_t;

    function automatic cfg_t decode_code(input logic [3:0] code, input logic chain_ok);
        cfg_t c;
        c.is_cap   = code[3];
        c.init_lvl = code[2];
        c.act      = code[3] ? ACT_NONE : act_e'(code[1:0]);
        if (!code[3])
            c.src = SRC_NONE;
        else if (chain_ok && code[2])
            c.src = SRC_CHAIN;
        else if (code[1])
            c.src = SRC_BOTH;
        else if (code[0])
            c.src = SRC_FALL;
        else
            c.src = SRC_RISE;
        return c;
    endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[LAST-1:0], pin_in};
    end

    assign rise = sh[LAST-1] & ~sh[LAST];
    assign fall = ~sh[LAST-1] & sh[LAST];

endmodule

// File: rtl/tcc_gen_reg.sv
module tcc_gen_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cmp_en,
    input  logic         cap_evt,
    input  logic [1:0]   flag_clr,
    output logic         match_evt,
    output logic [W-1:0] reg_q,
    output logic         match_flag,
    output logic         cap_flag
);
    assign match_evt = cmp_en && (cnt == reg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q      <= '0;
            match_flag <= 1'b0;
            cap_flag   <= 1'b0;
        end else begin
            if (cap_evt)
                reg_q <= cnt;
            else if (wr_en)
                reg_q <= wr_data;

            if (match_evt)
                match_flag <= 1'b1;
            else if (flag_clr[0])
                match_flag <= 1'b0;

            if (cap_evt)
                cap_flag <= 1'b1;
            else if (flag_clr[1])
                cap_flag <= 1'b0;
        end
    end

    // R5
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> match_flag);

    // R9
    cap_stores_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_flag && reg_q == $past(cnt)));

endmodule

// File: rtl/tcc_pin_out.sv
module tcc_pin_out
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  cfg_t nxt_cfg,
    input  cfg_t cur_cfg,
    input  logic match_evt,
    output logic pin_q,
    output logic oe_q
);
    logic nxt_active;
    assign nxt_active = !nxt_cfg.is_cap && (nxt_cfg.act != ACT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (ctl_wr) begin
            oe_q <= nxt_active;
            if (nxt_active)
                pin_q <= nxt_cfg.init_lvl;
        end else if (match_evt) begin
            case (cur_cfg.act)
                ACT_CLR: pin_q <= 1'b0;
                ACT_SET: pin_q <= 1'b1;
                ACT_TGL: pin_q <= ~pin_q;
                default: pin_q <= pin_q;
            endcase
        end
    end

    // R2
    init_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && nxt_active) |=> (oe_q && pin_q == $past(nxt_cfg.init_lvl)));

    // R3
    match_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && match_evt && cur_cfg.act == ACT_SET) |=> pin_q);

    // R3
    match_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && match_evt && cur_cfg.act == ACT_CLR) |=> !pin_q);

    // R3
    match_tgl_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && match_evt && cur_cfg.act == ACT_TGL) |=> (pin_q != $past(pin_q)));

    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr && !oe_q) |=> ($stable(pin_q) && !oe_q));

endmodule

// File: rtl/tcc_pin_ctrl.sv
module tcc_pin_ctrl
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit CASCADE     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_code,
    input  logic [1:0]       flag_clr,
    input  logic             pin_in,
    input  logic             companion_evt,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [CNT_W-1:0] reg_out,
    output logic             match_flag,
    output logic             cap_flag
);
    logic [3:0] ctl_q;
    cfg_t       cur_cfg;
    cfg_t       nxt_cfg;
    logic       rise;
    logic       fall;
    logic       cap_evt;
    logic       match_evt;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= 4'b0000;
        else if (ctl_wr)
            ctl_q <= ctl_code;
    end

    assign cur_cfg = decode_code(ctl_q, CASCADE);
    assign nxt_cfg = decode_code(ctl_code, CASCADE);

    always_comb begin
        case (cur_cfg.src)
            SRC_RISE:  cap_evt = rise;
            SRC_FALL:  cap_evt = fall;
            SRC_BOTH:  cap_evt = rise | fall;
            SRC_CHAIN: cap_evt = companion_evt;
            default:   cap_evt = 1'b0;
        endcase
    end

    tcc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    tcc_gen_reg #(.W(CNT_W)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .cnt        (cnt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmp_en     (!cur_cfg.is_cap),
        .cap_evt    (cap_evt),
        .flag_clr   (flag_clr),
        .match_evt  (match_evt),
        .reg_q      (reg_out),
        .match_flag (match_flag),
        .cap_flag   (cap_flag)
    );

    tcc_pin_out u_out (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .nxt_cfg   (nxt_cfg),
        .cur_cfg   (cur_cfg),
        .match_evt (match_evt),
        .pin_q     (pin_out),
        .oe_q      (pin_oe)
    );

    // R10
    cap_mode_oe_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q[3] |-> (!pin_oe && !match_evt));

endmodule

// File: tb/tcc_pin_ctrl_tb.sv
`timescale 1ns/1ps
module tcc_pin_ctrl_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt = 16'h0010;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ctl_wr = 1'b0;
    logic [3:0]   ctl_code = 4'h0;
    logic [1:0]   flag_clr = 2'b00;
    logic         pin_in = 1'b0;
    logic         companion_evt = 1'b0;

    logic         pin_out, pin_oe, match_flag, cap_flag;
    logic [W-1:0] reg_out;
    logic         nc_pin_out, nc_pin_oe, nc_match_flag, nc_cap_flag;
    logic [W-1:0] nc_reg_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tcc_pin_ctrl #(.CNT_W(W), .CASCADE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cnt(cnt), .wr_en(wr_en), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_code(ctl_code), .flag_clr(flag_clr),
        .pin_in(pin_in), .companion_evt(companion_evt),
        .pin_out(pin_out), .pin_oe(pin_oe), .reg_out(reg_out),
        .match_flag(match_flag), .cap_flag(cap_flag)
    );

    tcc_pin_ctrl #(.CNT_W(W), .CASCADE(1'b0)) u_dut_nc (
        .clk(clk), .rst(rst), .cnt(cnt), .wr_en(wr_en), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_code(ctl_code), .flag_clr(flag_clr),
        .pin_in(pin_in), .companion_evt(companion_evt),
        .pin_out(nc_pin_out), .pin_oe(nc_pin_oe), .reg_out(nc_reg_out),
        .match_flag(nc_match_flag), .cap_flag(nc_cap_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [3:0] c);
        ctl_code = c;
        ctl_wr = 1'b1;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic write_reg(input logic [W-1:0] v);
        wr_data = v;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        tick();
        flag_clr = 2'b00;
    endtask

    task automatic one_match();
        cnt = 16'h0040;
        tick();
        cnt = 16'h0010;
    endtask

    function automatic logic trig(input logic [3:0] c, input int k, input logic casc);
        if (!c[3]) return 1'b0;
        if (casc && c[2]) return (k == 2);
        if (k == 2) return 1'b0;
        if (c[1]) return 1'b1;
        return (k == 1) ? c[0] : !c[0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 oe", pin_oe, 0);
        check("R1 pin", pin_out, 0);
        check("R1 flags", {match_flag, cap_flag}, 0);
        check("R1 reg", reg_out, 0);

        write_reg(16'h0040);
        // R10 write port load
        check("R10 write", reg_out, 16'h0040);

        // Output sweep: codes 0..7, each with both prior pin levels
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [3:0] code;
                logic act_on;
                logic prior, e1, e2;
                code = 4'(c);
                prior = p[0];
                write_ctl(prior ? 4'h5 : 4'h1);
                clear_flags();
                write_ctl(code);
                act_on = (code[1:0] != 2'b00);
                // R2 initial level / R4 disabled hold
                check(act_on ? "R2 oe" : "R4 oe", pin_oe, act_on);
                check(act_on ? "R2 init" : "R4 hold", pin_out, act_on ? code[2] : prior);
                one_match();
                case (code[1:0])
                    2'b01:   e1 = 1'b0;
                    2'b10:   e1 = 1'b1;
                    2'b11:   e1 = ~code[2];
                    default: e1 = prior;
                endcase
                // R3 first match / R4 hold across match
                check(act_on ? "R3 match1" : "R4 match1", pin_out, e1);
                // R5 flag set
                check("R5 flag", match_flag, 1);
                one_match();
                e2 = (code[1:0] == 2'b11) ? ~e1 : e1;
                check(act_on ? "R3 match2" : "R4 match2", pin_out, e2);
                flag_clr = 2'b01;
                tick();
                flag_clr = 2'b00;
                // R5 clear
                check("R5 clear", match_flag, 0);
            end
        end

        // R5 set wins over clear
        flag_clr = 2'b01;
        cnt = 16'h0040;
        tick();
        cnt = 16'h0010;
        flag_clr = 2'b00;
        check("R5 set wins", match_flag, 1);

        // R6 no capture in output mode
        write_ctl(4'h3);
        clear_flags();
        pin_in = 1'b1;
        repeat (4) tick();
        pin_in = 1'b0;
        repeat (4) tick();
        check("R6 no cap in output", reg_out, 16'h0040);
        check("R6 no cap flag", cap_flag, 0);

        // Capture sweep: codes 8..15 with rise, fall, companion stimuli
        for (int c = 8; c < 16; c++) begin
            logic [3:0] code;
            code = 4'(c);
            write_ctl(4'h0);
            pin_in = 1'b0;
            repeat (4) tick();
            write_ctl(code);
            clear_flags();
            // R10 capture mode disables output
            check("R10 oe", {pin_oe, nc_pin_oe}, 0);
            for (int k = 0; k < 3; k++) begin
                logic [W-1:0] sent, val;
                logic ec, en;
                sent = 16'hA000 + 16'(k);
                val  = 16'h0100 + 16'(c * 16 + k);
                write_reg(sent);
                cnt = val;
                if (k == 0) begin
                    pin_in = 1'b1;
                    repeat (4) tick();
                end else if (k == 1) begin
                    pin_in = 1'b0;
                    repeat (4) tick();
                end else begin
                    companion_evt = 1'b1;
                    tick();
                    companion_evt = 1'b0;
                    tick();
                end
                ec = trig(code, k, 1'b1);
                en = trig(code, k, 1'b0);
                // R6 edge select, R7 cascade source
                check((code[2] && k == 2) ? "R7 reg" : "R6 reg", reg_out, ec ? val : sent);
                // R9 capture flag
                check("R9 flag", cap_flag, ec);
                // R8 non-cascade channel ignores bit 2
                check("R8 reg", nc_reg_out, en ? val : sent);
                check("R8 flag", nc_cap_flag, en);
                // R10 no match flag in capture mode
                check("R10 match", {match_flag, nc_match_flag}, 0);
                flag_clr = 2'b10;
                tick();
                flag_clr = 2'b00;
                check("R9 clear", cap_flag, 0);
                cnt = 16'h0010;
            end
        end

        // R6 capture latency: register changes on third edge after pin change
        write_ctl(4'h8);
        pin_in = 1'b0;
        repeat (4) tick();
        write_reg(16'h1234);
        cnt = 16'h0777;
        pin_in = 1'b1;
        tick();
        tick();
        check("R6 latency early", reg_out, 16'h1234);
        tick();
        check("R6 latency", reg_out, 16'h0777);

        // R9 capture wins over clear; R10 capture wins over write
        write_ctl(4'hC);
        clear_flags();
        flag_clr = 2'b10;
        companion_evt = 1'b1;
        wr_data = 16'h5555;
        wr_en = 1'b1;
        cnt = 16'h0999;
        tick();
        flag_clr = 2'b00;
        companion_evt = 1'b0;
        wr_en = 1'b0;
        check("R9 set wins", cap_flag, 1);
        check("R10 cap priority", reg_out, 16'h0999);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule